// File: doc/BRIEF.md
# Dual-Edge Latch Timestamp Capture

The block records the value of a free-running 64-bit system-time bus when events occur. There are two external latch pins. For each pin, a rising-edge timestamp and a falling-edge timestamp are held in separate slots. A fifth slot records the time of an internal buffer-manager event, which is useful for debugging. Each pin first passes through a synchronizer. The captured value is the system time present in the cycle in which the synchronized edge is detected.

Each slot has a "new" flag. A capture sets the flag, and reading the slot clears it. The mode of each pin is set separately:

- **Continuous:** every later edge overwrites the stored time.
- **Single-shot:** the first capture is kept until the slot is read.

A pin can also serve another purpose, such as a shared sync output. In that case the block ignores the pin unless it is configured as a latch input. Each latch unit can also be switched off to save power. A unit that is off captures nothing.

A host reads the block with a simple register read. It places a slot number on `rd_sel_i` and sees the slot's time on `rd_data_o` in the same cycle. Pulsing `rd_en_i` for one clock clears the flag of that slot.

Top module: `latch_stamp_unit`

## Requirements
- R1: After reset, all five flags are 0 and every slot reads 0.
- R2: The slot numbers on `rd_sel_i` are:

  | Slot | Contents |
  |------|----------|
  | 0 | Pin 0 rising edge |
  | 1 | Pin 0 falling edge |
  | 2 | Pin 1 rising edge |
  | 3 | Pin 1 falling edge |
  | 4 | Buffer-manager event |

  A capture stores the time and sets flag bit `new_flag_o[slot]`.
- R3: `rd_data_o` shows the stored time of the slot selected by `rd_sel_i` in the same cycle. When `rd_en_i` is high on a clock edge, that slot's flag is cleared.
- R4: With `single_shot_i[i]`=0, each new edge on pin i overwrites the stored time of the matching slot.
- R5: With `single_shot_i[i]`=1, further edges leave a slot unchanged while its flag is set. After the slot is read, the next edge captures again.
- R6: While `pin_is_latch_i[i]`=0, edges on pin i change neither the value nor the flag of its slots. Re-enabling the pin produces no capture unless a new edge follows.
- R7: While `unit_en_i[i]`=0, edges on pin i change neither the value nor the flag of its slots.
- R8: When `bufmgr_evt_i` is high on a clock edge, slot 4 stores the `sys_time_i` value present before that edge and sets its flag. Slot 4 always works in continuous mode.
- R9: A capture and a read-clear of the same slot can fall on the same edge. In that case the capture wins: the new time is stored and the flag stays 1, even in single-shot mode.
- R10: Suppose a pin changes between clock edges k-1 and k. The flag then rises after edge k+2, and the stored time is the `sys_time_i` value held between edges k+1 and k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_time_i | input | 64 | Free-running system time |
| latch_pin_i | input | 2 | Asynchronous latch pins |
| pin_is_latch_i | input | 2 | Pin configured as a latch input |
| unit_en_i | input | 2 | Latch unit powered (not in power-save) |
| single_shot_i | input | 2 | 1 = single-shot mode, 0 = continuous mode |
| bufmgr_evt_i | input | 1 | Internal buffer-manager event strobe |
| rd_en_i | input | 1 | Read strobe; clears the flag of the selected slot |
| rd_sel_i | input | 3 | Slot select (0 to 4) |
| rd_data_o | output | 64 | Stored time of the selected slot |
| new_flag_o | output | 5 | New-capture flag for each slot |

## Verification
A capture and a host read that clears the same slot's flag can occur in the same cycle. The bench provokes this on a single-shot slot whose flag is already set:

1. It drives a pin edge.
2. It counts two clock edges through the synchronizer.
3. It raises `rd_en_i` with that slot selected, so the read lands on the capture edge.

The check passes only if the flag is still set afterwards and the slot holds the new, later time rather than the earlier one.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;

  function automatic int slot_of(int pin, edge_e e);
    return 2 * pin + int'(e);
  endfunction
endpackage

// File: rtl/latch_edge_sync.sv
module latch_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;
  logic              s;

  assign s = sr_q[STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sr_q   <= {sr_q[STAGES-2:0], pin_i};
      prev_q <= s;
    end
  end

  assign rise_o = s & ~prev_q;
  assign fall_o = ~s & prev_q;

  // R10: a detected edge lasts one cycle
  a_r10_rise_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
  a_r10_fall_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/stamp_slot.sv
module stamp_slot #(
  parameter int TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              single_i,
  input  logic              clr_i,
  input  logic [TIME_W-1:0] time_i,
  output logic [TIME_W-1:0] value_o,
  output logic              flag_o
);
  logic take;

  // single-shot holds while flagged, unless the read lands this cycle
  assign take = cap_i & (~single_i | ~flag_o | clr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_o <= '0;
      flag_o  <= 1'b0;
    end else begin
      if (take) value_o <= time_i;
      if (take)       flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  a_r2_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_i |=> flag_o);
  a_r3_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !cap_i) |=> !flag_o);
  a_r4_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !single_i) |=> value_o == $past(time_i));
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (single_i && flag_o && !clr_i) |=> $stable(value_o));
  a_r9_capture_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && clr_i) |=> (flag_o && value_o == $past(time_i)));
endmodule

// File: rtl/stamp_rd_mux.sv
module stamp_rd_mux #(
  parameter  int N      = 5,
  parameter  int W      = 64,
  localparam int SEL_W  = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     vals_i [N],
  input  logic [SEL_W-1:0] sel_i,
  input  logic             rd_en_i,
  output logic [W-1:0]     data_o,
  output logic [N-1:0]     clr_o
);
  always_comb begin
    data_o = '0;
    clr_o  = '0;
    for (int k = 0; k < N; k++) begin
      if (sel_i == SEL_W'(k)) begin
        data_o   = vals_i[k];
        clr_o[k] = rd_en_i;
      end
    end
  end

  a_r3_one_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(clr_o));
  a_r3_clear_needs_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> clr_o == '0);
endmodule

// File: rtl/latch_stamp_unit.sv
module latch_stamp_unit #(
  parameter  int TIME_W      = 64,
  parameter  int N_LATCH     = 2,
  parameter  int SYNC_STAGES = 2,
  localparam int N_SLOT      = 2 * N_LATCH + 1,
  localparam int SEL_W       = $clog2(N_SLOT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] sys_time_i,
  input  logic [N_LATCH-1:0] latch_pin_i,
  input  logic [N_LATCH-1:0] pin_is_latch_i,
  input  logic [N_LATCH-1:0] unit_en_i,
  input  logic [N_LATCH-1:0] single_shot_i,
  input  logic              bufmgr_evt_i,
  input  logic              rd_en_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [TIME_W-1:0] rd_data_o,
  output logic [N_SLOT-1:0] new_flag_o
);
  import stamp_pkg::*;

  localparam int BM_SLOT = 2 * N_LATCH;

  logic [N_SLOT-1:0] cap;
  logic [N_SLOT-1:0] single;
  logic [N_SLOT-1:0] clr;
  logic [TIME_W-1:0] slot_val [N_SLOT];

  for (genvar i = 0; i < N_LATCH; i++) begin : g_pin
    logic rise, fall, live;

    latch_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (latch_pin_i[i]),
      .rise_o (rise),
      .fall_o (fall)
    );

    assign live = pin_is_latch_i[i] & unit_en_i[i];
    assign cap[slot_of(i, EDGE_RISE)]    = rise & live;
    assign cap[slot_of(i, EDGE_FALL)]    = fall & live;
    assign single[slot_of(i, EDGE_RISE)] = single_shot_i[i];
    assign single[slot_of(i, EDGE_FALL)] = single_shot_i[i];

    a_r6_r7_gate_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !live |=> $stable(slot_val[2*i]));
    a_r6_r7_gate_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !live |=> $stable(slot_val[2*i+1]));
    a_r6_r7_no_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!live && !rd_en_i) |=> $stable(new_flag_o[2*i+1:2*i]));
  end

  assign cap[BM_SLOT]    = bufmgr_evt_i;
  assign single[BM_SLOT] = 1'b0;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    stamp_slot #(.TIME_W(TIME_W)) u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cap_i    (cap[s]),
      .single_i (single[s]),
      .clr_i    (clr[s]),
      .time_i   (sys_time_i),
      .value_o  (slot_val[s]),
      .flag_o   (new_flag_o[s])
    );
  end

  stamp_rd_mux #(.N(N_SLOT), .W(TIME_W)) u_rd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vals_i  (slot_val),
    .sel_i   (rd_sel_i),
    .rd_en_i (rd_en_i),
    .data_o  (rd_data_o),
    .clr_o   (clr)
  );

  a_r8_bufmgr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bufmgr_evt_i |=> (new_flag_o[BM_SLOT] && slot_val[BM_SLOT] == $past(sys_time_i)));
endmodule

// File: tb/sim_latch_stamp_unit.sv
module sim_latch_stamp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] cyc = 64'hFFFF_FFFF_FFFF_FFF0;
  logic [1:0]  pin = '0, is_latch = 2'b11, en = 2'b11, single = 2'b00;
  logic        evt = 1'b0, rd_en = 1'b0;
  logic [2:0]  rd_sel = '0;
  logic [63:0] rd_data;
  logic [4:0]  flags;
  int          checks = 0, fails = 0;

  typedef struct {int slot; logic [63:0] val; logic flag; string req;} exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always_ff @(posedge clk) cyc <= cyc + 64'd1;

  latch_stamp_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .sys_time_i(cyc), .latch_pin_i(pin),
    .pin_is_latch_i(is_latch), .unit_en_i(en), .single_shot_i(single),
    .bufmgr_evt_i(evt), .rd_en_i(rd_en), .rd_sel_i(rd_sel),
    .rd_data_o(rd_data), .new_flag_o(flags)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(int i, logic v, output logic [63:0] c);
    c = cyc;
    pin[i] = v;
  endtask

  task automatic push(int s, logic [63:0] v, logic f, string r);
    exp_t it;
    it.slot = s; it.val = v; it.flag = f; it.req = r;
    q.push_back(it);
  endtask

  // monitor: pop each expectation, read the slot, compare, clear
  task automatic drain();
    while (q.size() > 0) begin
      exp_t it;
      it = q.pop_front();
      @(negedge clk);
      rd_sel = 3'(it.slot);
      #1;
      chk({it.req, " data"}, rd_data, it.val);
      chk({it.req, " flag"}, {63'b0, flags[it.slot]}, {63'b0, it.flag});
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [63:0] c, ca, cb, cd, ce, v0, v2;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 flags", {59'b0, flags}, 64'd0);
    for (int s = 0; s < 5; s++) begin
      rd_sel = 3'(s); #1;
      chk("R1 data", rd_data, 64'd0);
    end
    tick(1);
    // R2 all four edge slots
    set_pin(0, 1, c); push(0, c + 2, 1, "R2"); tick(4);
    set_pin(0, 0, c); push(1, c + 2, 1, "R2"); tick(4);
    set_pin(1, 1, c); push(2, c + 2, 1, "R2"); v2 = c + 2; tick(4);
    set_pin(1, 0, c); push(3, c + 2, 1, "R2"); tick(4);
    drain();
    tick(1);
    chk("R3 cleared", {59'b0, flags}, 64'd0);
    // R4 continuous overwrite
    set_pin(0, 1, c); tick(4);
    set_pin(0, 0, cb); tick(4);
    set_pin(0, 1, c); tick(4);
    push(0, c + 2, 1, "R4"); push(1, cb + 2, 1, "R4");
    drain();
    // R5 single-shot keeps first
    single = 2'b01;
    set_pin(0, 0, cd); tick(4);
    set_pin(0, 1, ce); tick(4);
    set_pin(0, 0, c); tick(4);
    set_pin(0, 1, c); tick(4);
    push(0, ce + 2, 1, "R5"); push(1, cd + 2, 1, "R5");
    v0 = ce + 2;
    drain();
    set_pin(0, 0, c); tick(4);
    push(1, c + 2, 1, "R5 rearm");
    drain();
    single = 2'b00;
    // R6 pin not configured as latch
    is_latch = 2'b01;
    set_pin(1, 1, c); tick(4);
    push(2, v2, 0, "R6");
    drain();
    is_latch = 2'b11; tick(4);
    chk("R6 no spurious", {59'b0, flags}, 64'd0);
    set_pin(1, 0, c); tick(4);
    push(3, c + 2, 1, "R6 restored");
    drain();
    // R7 unit powered down
    en = 2'b10;
    set_pin(0, 1, c); tick(4);
    push(0, v0, 0, "R7");
    drain();
    en = 2'b11; tick(4);
    set_pin(0, 0, c); tick(4);
    push(1, c + 2, 1, "R7 restored");
    drain();
    // R8 buffer-manager event
    c = cyc; evt = 1'b1; tick(1); evt = 1'b0; tick(2);
    push(4, c, 1, "R8");
    drain();
    evt = 1'b1; tick(1); evt = 1'b0; tick(2);
    c = cyc; evt = 1'b1; tick(1); evt = 1'b0; tick(2);
    push(4, c, 1, "R8 overwrite");
    drain();
    // R9 capture and read-clear on the same edge
    single = 2'b11;
    set_pin(0, 1, ca); tick(4);
    set_pin(0, 0, c); tick(4);
    set_pin(0, 1, c); tick(4);
    set_pin(0, 0, cb); tick(2);
    rd_sel = 3'd1; rd_en = 1'b1;
    tick(1);
    rd_en = 1'b0; #1;
    chk("R9 flag kept", {63'b0, flags[1]}, 64'd1);
    push(1, cb + 2, 1, "R9"); push(0, ca + 2, 1, "R9");
    drain();
    single = 2'b00;
    // R10 synchronizer latency
    set_pin(1, 1, c); tick(2); #1;
    chk("R10 early", {63'b0, flags[2]}, 64'd0);
    tick(1); #1;
    chk("R10 on time", {63'b0, flags[2]}, 64'd1);
    push(2, c + 2, 1, "R10");
    drain();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule